// File: doc/BRIEF.md
# Sector Frame Parser

This block sits behind the byte assembler of a floppy read channel. It scans the incoming bytes for the sync run that precedes every header and every data field: a 0xBF, five 0xFF bytes and a 0xFE. It then inspects the lead byte that follows. A header has the lead 0xAB, carries a 16-bit track code and a 16-bit sector code, and closes with 0xDD. A data field has the lead 0xED, carries 416 code bytes and closes with 0xF5 followed by 0xDD. Filler bytes between fields are skipped.

The host first converts the wanted logical track and sector into 16-bit codes, including the shift of two between logical and physical track. It presents these codes together with a start pulse. From then on the parser looks for a header whose codes equal the request. It gates only the data field that follows that header through to the symbol decoder, and tags each data byte with its index. Wrong headers and damaged markers are reported through sticky flags while the search goes on. After one complete sector the parser goes idle until the next start.

Top module: `sector_frame_parser`

## Requirements
- R1: Before the first start pulse the parser reacts to no byte. A start pulse clears markerErr and idMismatch, captures reqTrackCode and reqSectorCode, and begins a new search.
- R2: A sync run is the bytes 0xBF, 0xFF x5, 0xFE, and the next byte is taken as the lead. A run that breaks early is dropped without setting any flag.
- R3: A header is the lead 0xAB, then the track code and the sector code (each high byte first), then the trail 0xDD. If both codes equal the captured request, hdrFound pulses for one cycle, in the cycle after the trail byte is accepted.
- R4: A header with a correct trail whose codes differ from the request sets idMismatch, and the search for the requested header continues.
- R5: A data field (lead 0xED) is accepted only when it follows a matching header. While it is accepted, dataGate is high for exactly 416 valid bytes, and byteCount shows the index 0..415 of the byte currently presented. A data field that follows no matching header is never gated.
- R6: When a gated data field ends with the bytes 0xF5 then 0xDD, dataDone pulses for one cycle. The parser then ignores all further bytes until the next start.
- R7: After a sync run, a lead byte other than 0xAB or 0xED sets markerErr. So does a header trail other than 0xDD, or a data trail that differs from 0xF5, 0xDD. markerErr stays set until the next start, and the parser goes back to hunting.
- R8: After a matching header, the data lead must arrive within the first 64 valid bytes that follow the header trail, the lead itself included. Otherwise the header is dropped without a flag and the data field is not gated.
- R9: Cycles with byteValid low change no state: byteCount, dataGate and the parse position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new sector search and clear flags |
| reqTrackCode | input | 16 | Coded physical track wanted, captured on start |
| reqSectorCode | input | 16 | Coded sector wanted, captured on start |
| byteValid | input | 1 | byteIn carries a new byte this cycle |
| byteIn | input | 8 | Byte from the read channel |
| hdrFound | output | 1 | One-cycle pulse: requested header seen |
| dataGate | output | 1 | Current byteIn belongs to the accepted data field |
| byteCount | output | 9 | Index of the gated byte within the data field |
| dataDone | output | 1 | One-cycle pulse: data trailer correct |
| markerErr | output | 1 | Sticky: a lead or trail marker was wrong |
| idMismatch | output | 1 | Sticky: a header for another track or sector was seen |

## Verification
The bench targets the data-lead window at both edges, with the lead as the 64th and then the 65th byte after the header trail. A design that counts the window off by one would drop a legal sector or accept a late one. A broken sync run placed directly before a good sector checks that only a complete run arms lead decoding; an over-eager matcher would raise markerErr or miss the sector. Data fields behind a mismatching header, and data fields sent with no header at all, must never open the gate, and a second sector after dataDone must be ignored. Random idle cycles inside fields catch a design that advances its position on invalid cycles, which would show up as shifted byte indices.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] SYNC_HEAD = 8'hBF;
  localparam logic [BYTE_W-1:0] SYNC_FILL = 8'hFF;
  localparam logic [BYTE_W-1:0] SYNC_TAIL = 8'hFE;
  localparam logic [BYTE_W-1:0] LEAD_HDR  = 8'hAB;
  localparam logic [BYTE_W-1:0] LEAD_DAT  = 8'hED;
  localparam logic [BYTE_W-1:0] TRAIL_HDR = 8'hDD;
  localparam logic [BYTE_W-1:0] TRAIL_D1  = 8'hF5;
  localparam logic [BYTE_W-1:0] TRAIL_D2  = 8'hDD;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_SYNC, ST_HDR, ST_HDR_TRAIL,
    ST_WAIT_DSYNC, ST_DATA, ST_DATA_TRAIL
  } parseState_t;

  typedef struct packed {
    logic restart;
    logic posClr;
    logic posInc;
    logic hdrShift;
    logic winClr;
    logic winInc;
    logic markErr;
    logic idErr;
    logic hdrHit;
    logic secDone;
  } strobe_t;

endpackage

// File: rtl/sfp_datapath.sv
module sfp_datapath
  import sfp_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int POS_W  = 9,
  parameter int WIN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [CODE_W-1:0] reqTrackCode,
  input  logic [CODE_W-1:0] reqSectorCode,
  output logic [POS_W-1:0]  posCnt,
  output logic [WIN_W-1:0]  winCnt,
  output logic              idMatch,
  output logic              hdrFound,
  output logic              dataDone,
  output logic              markerErr,
  output logic              idMismatch
);

  localparam int ID_W = 2 * CODE_W;

  logic [CODE_W-1:0] wantTrack, wantSector;
  logic [ID_W-1:0]   hdrReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wantTrack  <= '0;
      wantSector <= '0;
      hdrReg     <= '0;
      posCnt     <= '0;
      winCnt     <= '0;
      hdrFound   <= 1'b0;
      dataDone   <= 1'b0;
      markerErr  <= 1'b0;
      idMismatch <= 1'b0;
    end else begin
      if (strb.restart) begin
        wantTrack  <= reqTrackCode;
        wantSector <= reqSectorCode;
      end
      if (strb.posClr)      posCnt <= '0;
      else if (strb.posInc) posCnt <= posCnt + 1'b1;
      if (strb.winClr)      winCnt <= '0;
      else if (strb.winInc) winCnt <= winCnt + 1'b1;
      if (strb.hdrShift) hdrReg <= {hdrReg[ID_W-BYTE_W-1:0], byteIn};
      if (strb.restart) begin
        markerErr  <= 1'b0;
        idMismatch <= 1'b0;
      end else begin
        if (strb.markErr) markerErr  <= 1'b1;
        if (strb.idErr)   idMismatch <= 1'b1;
      end
      hdrFound <= strb.hdrHit;
      dataDone <= strb.secDone;
    end
  end

  assign idMatch = (hdrReg == {wantTrack, wantSector});

endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int DATA_LEN  = 416,
  parameter int SYNC_FF_N = 5,
  parameter int WIN_LEN   = 64,
  parameter int HDR_BYTES = 4,
  parameter int POS_W     = 9,
  parameter int WIN_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [POS_W-1:0]  posCnt,
  input  logic [WIN_W-1:0]  winCnt,
  input  logic              idMatch,
  output strobe_t           strb,
  output parseState_t       state
);

  localparam logic [POS_W-1:0] FF_LAST   = POS_W'(SYNC_FF_N);
  localparam logic [POS_W-1:0] DATA_LAST = POS_W'(DATA_LEN - 1);
  localparam logic [POS_W-1:0] HDR_LAST  = POS_W'(HDR_BYTES - 1);
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(WIN_LEN - 1);

  parseState_t stateNext;
  logic armed, armedNext;
  parseState_t huntState;

  assign huntState = armed ? ST_WAIT_DSYNC : ST_HUNT;

  always_comb begin
    stateNext = state;
    armedNext = armed;
    strb      = '0;
    if (start) begin
      strb.restart = 1'b1;
      strb.posClr  = 1'b1;
      strb.winClr  = 1'b1;
      stateNext    = ST_HUNT;
      armedNext    = 1'b0;
    end else if (byteValid) begin
      unique case (state)
        ST_IDLE: ;
        ST_HUNT, ST_WAIT_DSYNC: begin
          if (byteIn == SYNC_HEAD) begin
            stateNext   = ST_SYNC;
            strb.posClr = 1'b1;
          end
        end
        ST_SYNC: begin
          if (posCnt <= FF_LAST) begin
            if (byteIn == ((posCnt == FF_LAST) ? SYNC_TAIL : SYNC_FILL))
              strb.posInc = 1'b1;
            else if (byteIn == SYNC_HEAD)
              strb.posClr = 1'b1;
            else
              stateNext = huntState;
          end else begin
            strb.posClr = 1'b1;
            if (byteIn == LEAD_HDR) begin
              stateNext = ST_HDR;
              armedNext = 1'b0;
            end else if (byteIn == LEAD_DAT) begin
              stateNext = armed ? ST_DATA : ST_HUNT;
              armedNext = 1'b0;
            end else begin
              strb.markErr = 1'b1;
              stateNext    = ST_HUNT;
              armedNext    = 1'b0;
            end
          end
        end
        ST_HDR: begin
          strb.hdrShift = 1'b1;
          if (posCnt == HDR_LAST) begin
            strb.posClr = 1'b1;
            stateNext   = ST_HDR_TRAIL;
          end else begin
            strb.posInc = 1'b1;
          end
        end
        ST_HDR_TRAIL: begin
          if (byteIn != TRAIL_HDR) begin
            strb.markErr = 1'b1;
            stateNext    = ST_HUNT;
          end else if (idMatch) begin
            strb.hdrHit = 1'b1;
            strb.winClr = 1'b1;
            stateNext   = ST_WAIT_DSYNC;
            armedNext   = 1'b1;
          end else begin
            strb.idErr = 1'b1;
            stateNext  = ST_HUNT;
          end
        end
        ST_DATA: begin
          if (posCnt == DATA_LAST) begin
            strb.posClr = 1'b1;
            stateNext   = ST_DATA_TRAIL;
          end else begin
            strb.posInc = 1'b1;
          end
        end
        ST_DATA_TRAIL: begin
          if (posCnt == '0) begin
            if (byteIn == TRAIL_D1) strb.posInc = 1'b1;
            else begin
              strb.markErr = 1'b1;
              stateNext    = ST_HUNT;
            end
          end else if (byteIn == TRAIL_D2) begin
            strb.secDone = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            strb.markErr = 1'b1;
            stateNext    = ST_HUNT;
          end
        end
      endcase
      // data-lead window after a matching header
      if (armed && (state == ST_WAIT_DSYNC || state == ST_SYNC) &&
          stateNext != ST_DATA && stateNext != ST_HDR) begin
        if (winCnt == WIN_LAST) begin
          stateNext = ST_HUNT;
          armedNext = 1'b0;
        end else begin
          strb.winInc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNext;
      armed <= armedNext;
    end
  end

endmodule

// File: rtl/sector_frame_parser.sv
module sector_frame_parser
  import sfp_pkg::*;
#(
  parameter int CODE_W    = 16,
  parameter int DATA_LEN  = 416,
  parameter int SYNC_FF_N = 5,
  parameter int WIN_LEN   = 64,
  parameter int COUNT_W   = $clog2(DATA_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  reqTrackCode,
  input  logic [CODE_W-1:0]  reqSectorCode,
  input  logic               byteValid,
  input  logic [BYTE_W-1:0]  byteIn,
  output logic               hdrFound,
  output logic               dataGate,
  output logic [COUNT_W-1:0] byteCount,
  output logic               dataDone,
  output logic               markerErr,
  output logic               idMismatch
);

  localparam int HDR_BYTES = 2 * CODE_W / BYTE_W;
  localparam int WIN_W     = $clog2(WIN_LEN);

  strobe_t            strb;
  parseState_t        state;
  logic [COUNT_W-1:0] posCnt;
  logic [WIN_W-1:0]   winCnt;
  logic               idMatch;

  sfp_ctrl #(
    .DATA_LEN(DATA_LEN), .SYNC_FF_N(SYNC_FF_N), .WIN_LEN(WIN_LEN),
    .HDR_BYTES(HDR_BYTES), .POS_W(COUNT_W), .WIN_W(WIN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byteValid(byteValid),
    .byteIn(byteIn), .posCnt(posCnt), .winCnt(winCnt), .idMatch(idMatch),
    .strb(strb), .state(state)
  );

  sfp_datapath #(
    .CODE_W(CODE_W), .POS_W(COUNT_W), .WIN_W(WIN_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .byteIn(byteIn),
    .reqTrackCode(reqTrackCode), .reqSectorCode(reqSectorCode),
    .posCnt(posCnt), .winCnt(winCnt), .idMatch(idMatch),
    .hdrFound(hdrFound), .dataDone(dataDone),
    .markerErr(markerErr), .idMismatch(idMismatch)
  );

  assign dataGate  = (state == ST_DATA);
  assign byteCount = dataGate ? posCnt : '0;

endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int DATA_LEN = 416,
  parameter int COUNT_W  = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               byteValid,
  input logic               hdrFound,
  input logic               dataGate,
  input logic [COUNT_W-1:0] byteCount,
  input logic               dataDone,
  input logic               markerErr,
  input logic               idMismatch
);

  assert_start_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !markerErr && !idMismatch && !dataGate);

  assert_hdr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdrFound |=> !hdrFound);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dataGate |-> byteCount < COUNT_W'(DATA_LEN));

  assert_gate_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataGate) |-> byteCount == '0);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dataGate && byteValid && !start && byteCount != COUNT_W'(DATA_LEN - 1))
      |=> dataGate && byteCount == COUNT_W'($past(byteCount) + 1'b1));

  assert_done_ungated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dataDone |-> !dataGate);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (markerErr && !start) |=> markerErr);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dataGate && !byteValid && !start) |=> dataGate && $stable(byteCount));

endmodule

bind sector_frame_parser sfp_checker #(.DATA_LEN(DATA_LEN), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byteValid(byteValid),
  .hdrFound(hdrFound), .dataGate(dataGate), .byteCount(byteCount),
  .dataDone(dataDone), .markerErr(markerErr), .idMismatch(idMismatch)
);

// File: tb/tb_sector_frame_parser.sv
module tb_sector_frame_parser;

  localparam int DLEN = 416;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, byteValid;
  logic [15:0] reqTrackCode, reqSectorCode;
  logic [7:0]  byteIn;
  logic        hdrFound, dataGate, dataDone, markerErr, idMismatch;
  logic [8:0]  byteCount;

  sector_frame_parser dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .reqTrackCode(reqTrackCode), .reqSectorCode(reqSectorCode),
    .byteValid(byteValid), .byteIn(byteIn),
    .hdrFound(hdrFound), .dataGate(dataGate), .byteCount(byteCount),
    .dataDone(dataDone), .markerErr(markerErr), .idMismatch(idMismatch)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int hdrCnt = 0, doneCnt = 0, idxErr = 0;
  logic [7:0] q[$], got[$], expData[$];
  logic [15:0] codes[4] = '{16'hEFDA, 16'hADB7, 16'hBEFB, 16'hDEEB};

  always @(negedge clk) if (rst_n) begin
    if (hdrFound) hdrCnt++;
    if (dataDone) doneCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic addSync();
    q.push_back(8'hBF);
    repeat (5) q.push_back(8'hFF);
    q.push_back(8'hFE);
  endtask

  task automatic addSector(input logic [15:0] t, input logic [15:0] s,
                           input logic [7:0] hLead, input logic [7:0] hTrail,
                           input int gap, input logic [7:0] dLead,
                           input logic [7:0] dT1, input logic [7:0] dT2, input bit keep);
    repeat (4) q.push_back(8'hAA);
    addSync();
    q.push_back(hLead);
    q.push_back(t[15:8]); q.push_back(t[7:0]);
    q.push_back(s[15:8]); q.push_back(s[7:0]);
    q.push_back(hTrail);
    repeat (gap) q.push_back(8'hAA);
    addSync();
    q.push_back(dLead);
    for (int i = 0; i < DLEN; i++) begin
      logic [7:0] b;
      b = 8'($urandom_range(0, 255));
      q.push_back(b);
      if (keep) expData.push_back(b);
    end
    q.push_back(dT1); q.push_back(dT2);
    repeat (4) q.push_back(8'hDD);
  endtask

  task automatic goodSector(input logic [15:0] t, input logic [15:0] s, input bit keep);
    addSector(t, s, 8'hAB, 8'hDD, 10, 8'hED, 8'hF5, 8'hDD, keep);
  endtask

  task automatic play();
    for (int i = 0; i < q.size(); i++) begin
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk); byteValid = 1'b0; byteIn = 8'h00;
        @(posedge clk);
      end
      @(negedge clk); byteValid = 1'b1; byteIn = q[i];
      #1;
      if (dataGate) begin
        if (int'(byteCount) != got.size()) idxErr++;
        got.push_back(q[i]);
      end
      @(posedge clk);
    end
    @(negedge clk); byteValid = 1'b0;
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic newCase();
    hdrCnt = 0; doneCnt = 0; idxErr = 0;
    got.delete(); expData.delete();
  endtask

  task automatic doStart(input logic [15:0] t, input logic [15:0] s);
    @(negedge clk); start = 1'b1; reqTrackCode = t; reqSectorCode = s;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic checkData(input string req);
    int bad = 0;
    chk(got.size() == expData.size(), {req, " gated byte total"}, got.size(), expData.size());
    if (got.size() == expData.size())
      for (int i = 0; i < got.size(); i++) if (got[i] != expData[i]) bad++;
    chk(bad == 0, {req, " gated byte values"}, bad, 0);
    chk(idxErr == 0, {req, " byteCount index"}, idxErr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 1'b0; byteValid = 1'b0; byteIn = 8'h00;
    reqTrackCode = 16'h0; reqSectorCode = 16'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({hdrFound, dataGate, dataDone, markerErr, idMismatch} == 5'b0, "R1 reset outputs",
        {hdrFound, dataGate, dataDone, markerErr, idMismatch}, 0);
    chk(byteCount == 0, "R1 reset byteCount", byteCount, 0);
    rst_n = 1'b1;

    // R1: no start yet, a full matching sector is ignored
    newCase();
    goodSector(16'hEFDA, 16'hEFDA, 1'b0);
    play();
    chk(hdrCnt == 0, "R1 header before start", hdrCnt, 0);
    chk(got.size() == 0, "R1 gate before start", got.size(), 0);

    // R2 R3 R5 R6 R9: clean sector with idle gaps
    newCase();
    doStart(16'hEFDA, 16'hADB7);
    goodSector(16'hEFDA, 16'hADB7, 1'b1);
    play();
    chk(hdrCnt == 1, "R3 hdrFound pulses", hdrCnt, 1);
    checkData("R5");
    chk(doneCnt == 1, "R6 dataDone pulses", doneCnt, 1);
    chk(markerErr == 0 && idMismatch == 0, "R7 no flags on clean sector", {markerErr, idMismatch}, 0);

    // R6: parser idle after a completed sector
    newCase();
    goodSector(16'hEFDA, 16'hADB7, 1'b0);
    play();
    chk(hdrCnt == 0 && got.size() == 0, "R6 ignored after done", hdrCnt + got.size(), 0);

    // R2: broken sync run before a good sector raises nothing
    newCase();
    doStart(16'hBEFB, 16'hDEEB);
    q.push_back(8'hBF); repeat (4) q.push_back(8'hFF); q.push_back(8'hFE);
    q.push_back(8'hAB);
    goodSector(16'hBEFB, 16'hDEEB, 1'b1);
    play();
    chk(markerErr == 0, "R2 broken sync silent", markerErr, 0);
    chk(hdrCnt == 1, "R2 sector after broken sync", hdrCnt, 1);
    checkData("R2");

    // R5: data field with no header is not gated
    newCase();
    doStart(16'hBEFB, 16'hDEEB);
    repeat (6) q.push_back(8'hAA);
    addSync(); q.push_back(8'hED);
    repeat (DLEN) q.push_back(8'h5A);
    play();
    chk(got.size() == 0, "R5 orphan data not gated", got.size(), 0);

    // R7: bad header trail
    newCase();
    doStart(16'hEFDA, 16'hADB7);
    addSector(16'hEFDA, 16'hADB7, 8'hAB, 8'hDE, 10, 8'hED, 8'hF5, 8'hDD, 1'b0);
    play();
    chk(markerErr == 1, "R7 bad header trail flag", markerErr, 1);
    chk(hdrCnt == 0 && got.size() == 0, "R7 bad header trail no gate", hdrCnt + got.size(), 0);

    // R1: start clears the sticky flag
    doStart(16'hEFDA, 16'hADB7);
    chk(markerErr == 0, "R1 start clears markerErr", markerErr, 0);

    // R7: unknown lead byte
    newCase();
    addSector(16'hEFDA, 16'hADB7, 8'hAC, 8'hDD, 10, 8'hED, 8'hF5, 8'hDD, 1'b0);
    play();
    chk(markerErr == 1, "R7 unknown lead flag", markerErr, 1);

    // R7: bad data trail, data still gated, no done
    newCase();
    doStart(16'hEFDA, 16'hADB7);
    addSector(16'hEFDA, 16'hADB7, 8'hAB, 8'hDD, 10, 8'hED, 8'hF4, 8'hDD, 1'b1);
    play();
    checkData("R7");
    chk(doneCnt == 0, "R7 no done on bad trail", doneCnt, 0);
    chk(markerErr == 1, "R7 bad data trail flag", markerErr, 1);

    // R4: wrong sector then right one
    newCase();
    doStart(16'hADB7, 16'hBEFB);
    goodSector(16'hADB7, 16'hDEEB, 1'b0);
    goodSector(16'hADB7, 16'hBEFB, 1'b1);
    play();
    chk(idMismatch == 1, "R4 idMismatch set", idMismatch, 1);
    chk(hdrCnt == 1, "R4 one matching header", hdrCnt, 1);
    checkData("R4");

    // R8: lead as 64th byte after trail is accepted
    newCase();
    doStart(16'hDEEB, 16'hEFDA);
    addSector(16'hDEEB, 16'hEFDA, 8'hAB, 8'hDD, 56, 8'hED, 8'hF5, 8'hDD, 1'b1);
    play();
    checkData("R8 edge");
    chk(doneCnt == 1, "R8 edge done", doneCnt, 1);

    // R8: lead as 65th byte is too late
    newCase();
    doStart(16'hDEEB, 16'hEFDA);
    addSector(16'hDEEB, 16'hEFDA, 8'hAB, 8'hDD, 57, 8'hED, 8'hF5, 8'hDD, 1'b0);
    play();
    chk(hdrCnt == 1, "R8 late header seen", hdrCnt, 1);
    chk(got.size() == 0 && doneCnt == 0, "R8 late data dropped", got.size() + doneCnt, 0);
    chk(markerErr == 0, "R8 late no flag", markerErr, 0);

    // Random sequences: R3 R4 R5 R6 R9
    for (int it = 0; it < 20; it++) begin
      int wt, ws, k;
      newCase();
      wt = $urandom_range(0, 3);
      ws = $urandom_range(0, 3);
      k  = $urandom_range(0, 2);
      doStart(codes[wt], codes[ws]);
      for (int j = 0; j < k; j++)
        addSector(codes[wt], codes[(ws + 1 + $urandom_range(0, 2)) % 4], 8'hAB, 8'hDD,
                  $urandom_range(0, 40), 8'hED, 8'hF5, 8'hDD, 1'b0);
      addSector(codes[wt], codes[ws], 8'hAB, 8'hDD, $urandom_range(0, 40),
                8'hED, 8'hF5, 8'hDD, 1'b1);
      play();
      chk(idMismatch == (k > 0), "R4 random idMismatch", idMismatch, (k > 0));
      chk(hdrCnt == 1 && doneCnt == 1, "R6 random pulses", hdrCnt * 10 + doneCnt, 11);
      checkData("R5 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule